// File: doc/BRIEF.md
# Tagged FIFO Message Cell

A single storage cell that lets hardware threads hand 64-bit messages to each other through a small first-in first-out queue. Every access is a one-cycle request carrying a requester number, a view code, a read/write flag and write data; the cell answers on the following cycle with read data or with a stall indication that names the requester which could not complete.

The cell offers four views of the same storage. The raw view peeks at the oldest entry or patches the newest one without touching the flags. The tag view reads and writes the empty, full and user flags and reports fill level and configuration. The waiting view and the polling view push and pop messages; the waiting view refuses to complete on an empty read or a full write, records the requester in a pending set and reports a stall, while the polling view always completes. When any push or pop completes, every recorded requester is released through a one-cycle wake vector, and the scheduler outside the block retries them.

A build-time switch turns the cell into a plain non-queue cell, in which the push/pop views do nothing.

Top module: `msg_cell_fifo`

## Requirements
- R1: After reset a queue cell reads through the tag view as: bits 31:28 the base-2 log of the depth, bits 18 upward the fill count (0), bit 17 the queue-mode flag (1), bit 16 the user flag (0), bit 1 the full flag (0), bit 0 the empty flag (1); the pending set is empty, so the first completed push after reset wakes nobody. For the default depth of 4 the word is 0x20020001.
- R2: Every request with `req_valid` high produces `rsp_valid` high exactly one cycle later, and no response appears without a request; writes and stalled accesses return read data 0.
- R3: A tag-view write loads the user flag from bit 16, the empty flag from bit 0 and the full flag from bit 1; when the loaded empty flag is 1 the fill count becomes 0, otherwise the count is kept.
- R4: A completed push (view code 3, or view code 2 when not stalled) clears the empty flag, stores the data in slot (head pointer + count) modulo the depth when the count is below the depth, and sets the full flag once the count equals the depth; a polling push into a full queue drops its data.
- R5: A completed pop clears the full flag, returns the oldest entry and advances the head pointer modulo the depth when the count is nonzero, returns 0 when the count is zero, and sets the empty flag once the count is zero.
- R6: A waiting-view read (view code 2) while the empty flag is set stalls: it pops nothing, clears the full flag, adds the requester to the pending set, and drives `rsp_stall` with `rsp_stall_id` equal to the requester.
- R7: A waiting-view write while the full flag is set stalls: it stores nothing, clears the empty flag and records the requester, even when the full flag was set through the tag view with room left.
- R8: Any completed push or pop drives the whole pending set onto `wake_vec` for one cycle and empties the set; several stalled requesters accumulate until then, and a stalled access never wakes.
- R9: A raw-view read (view code 0) returns the entry at the head pointer without popping; a raw-view write overwrites the newest entry, slot (head + count − 1) modulo depth, only when the count is nonzero, and is otherwise dropped.
- R10: View codes are 0 raw, 1 tag, 2 waiting push/pop, 3 polling push/pop.
- R11: With queue mode off, the tag word resets to 0, push/pop reads return 0 without stalling or popping, and push/pop writes change no flag and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_id | input | ID_W (6) | Requester number |
| req_view | input | 2 | View code (R10) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (64) | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_rdata | output | DATA_W (64) | Read data |
| rsp_stall | output | 1 | Last cycle's access was refused and recorded |
| rsp_stall_id | output | ID_W (6) | Requester that stalled |
| wake_vec | output | N_REQ (64) | One-cycle release pulse, one bit per requester |

## Verification
The bench aims at wrap-around of the head pointer with a raw-view patch of the newest slot; a design that computed the patch slot from the tail instead of head plus count minus one would hand the wrong message to the last pop. It pushes into a full queue through the polling view, where a design that bumped the count anyway would report a fill of five and corrupt the oldest slot. It sets the full flag through the tag view with room left and expects a waiting write to stall, which catches a design that tests the count rather than the flag, and it issues a raw write on an empty queue, where a design without the nonzero-count guard would overwrite the stale head. Wake pulses are checked for exact membership and for lasting one cycle, so a design that kept the pending set after a release or woke on a stalled access shows extra bits.

// File: rtl/msg_cell_pkg.sv
package msg_cell_pkg;

  typedef enum logic [1:0] {
    VW_RAW  = 2'd0,
    VW_TAG  = 2'd1,
    VW_WAIT = 2'd2,
    VW_POLL = 2'd3
  } view_e;

  localparam int TAG_LOG2_LSB = 28;
  localparam int TAG_LOG2_W   = 4;
  localparam int TAG_CNT_LSB  = 18;
  localparam int TAG_MODE_BIT = 17;
  localparam int TAG_USER_BIT = 16;
  localparam int TAG_FULL_BIT = 1;
  localparam int TAG_EMPT_BIT = 0;

endpackage

// File: rtl/msg_cell_store.sv
module msg_cell_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  head_slot,
  output logic [DATA_W-1:0] head_data
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_slot == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign head_data = slot_q[head_slot];

endmodule

// File: rtl/msg_cell_waitq.sv
module msg_cell_waitq #(
  parameter int N_REQ = 64,
  localparam int ID_W = $clog2(N_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic [ID_W-1:0]  rec_id,
  input  logic             release_en,
  output logic [N_REQ-1:0] pend_mask,
  output logic [N_REQ-1:0] wake_vec
);

  logic [N_REQ-1:0] pend_q, pend_d;
  logic [N_REQ-1:0] wake_q, wake_d;
  logic [N_REQ-1:0] rec_bit;

  always_comb begin
    rec_bit = '0;
    if (rec_en) begin
      rec_bit = N_REQ'(1) << rec_id;
    end
    wake_d = '0;
    pend_d = pend_q | rec_bit;
    if (release_en) begin
      wake_d = pend_q;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      wake_q <= '0;
    end else begin
      pend_q <= pend_d;
      wake_q <= wake_d;
    end
  end

  assign pend_mask = pend_q;
  assign wake_vec  = wake_q;

endmodule

// File: rtl/msg_cell_tag.sv
module msg_cell_tag
  import msg_cell_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 64,
  parameter bit FIFO_MODE = 1'b1,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  view_e             acc_view,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] head_data,
  output logic [PTR_W-1:0]  head_ptr,
  output logic              st_we,
  output logic [PTR_W-1:0]  st_slot,
  output logic [DATA_W-1:0] rdata_d,
  output logic              stall_d,
  output logic              release_d,
  output logic [CNT_W-1:0]  fill_cnt
);

  localparam logic [CNT_W-1:0]      DEPTH_C = CNT_W'(DEPTH);
  localparam logic [TAG_LOG2_W-1:0] LOG2_C  = FIFO_MODE ? TAG_LOG2_W'(PTR_W) : '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic             usr_q, usr_d;
  logic             emp_q, emp_d;
  logic             ful_q, ful_d;
  logic [CNT_W-1:0] tail_sum;
  logic [CNT_W-1:0] last_sum;
  logic [DATA_W-1:0] tag_word;
  logic             blocking;

  assign tail_sum = {1'b0, rd_q} + cnt_q;
  assign last_sum = tail_sum - CNT_W'(1);
  assign blocking = (acc_view == VW_WAIT);

  always_comb begin
    tag_word = '0;
    tag_word[TAG_LOG2_LSB +: TAG_LOG2_W] = LOG2_C;
    tag_word[TAG_CNT_LSB +: CNT_W]       = cnt_q;
    tag_word[TAG_MODE_BIT]               = FIFO_MODE;
    tag_word[TAG_USER_BIT]               = usr_q;
    tag_word[TAG_FULL_BIT]               = ful_q;
    tag_word[TAG_EMPT_BIT]               = emp_q;
  end

  always_comb begin
    cnt_d     = cnt_q;
    rd_d      = rd_q;
    usr_d     = usr_q;
    emp_d     = emp_q;
    ful_d     = ful_q;
    st_we     = 1'b0;
    st_slot   = tail_sum[PTR_W-1:0];
    rdata_d   = '0;
    stall_d   = 1'b0;
    release_d = 1'b0;
    if (acc_valid) begin
      unique case (acc_view)
        VW_RAW: begin
          if (!acc_write) begin
            rdata_d = head_data;
          end else if (FIFO_MODE && (cnt_q != '0)) begin
            st_we   = 1'b1;
            st_slot = last_sum[PTR_W-1:0];
          end
        end
        VW_TAG: begin
          if (!acc_write) begin
            rdata_d = tag_word;
          end else begin
            usr_d = acc_wdata[TAG_USER_BIT];
            emp_d = acc_wdata[TAG_EMPT_BIT];
            ful_d = acc_wdata[TAG_FULL_BIT];
            if (acc_wdata[TAG_EMPT_BIT]) begin
              cnt_d = '0;
            end
          end
        end
        VW_WAIT, VW_POLL: begin
          if (FIFO_MODE) begin
            if (!acc_write) begin
              ful_d = 1'b0;
              if (blocking && emp_q) begin
                stall_d = 1'b1;
              end else begin
                release_d = 1'b1;
                if (cnt_q != '0) begin
                  rdata_d = head_data;
                  rd_d    = rd_q + PTR_W'(1);
                  cnt_d   = cnt_q - CNT_W'(1);
                end
                if (cnt_d == '0) begin
                  emp_d = 1'b1;
                end
              end
            end else begin
              emp_d = 1'b0;
              if (blocking && ful_q) begin
                stall_d = 1'b1;
              end else begin
                release_d = 1'b1;
                if (cnt_q < DEPTH_C) begin
                  st_we = 1'b1;
                  cnt_d = cnt_q + CNT_W'(1);
                end
                if (cnt_d == DEPTH_C) begin
                  ful_d = 1'b1;
                end
              end
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
      usr_q <= 1'b0;
      emp_q <= FIFO_MODE;
      ful_q <= 1'b0;
    end else if (acc_valid) begin
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      usr_q <= usr_d;
      emp_q <= emp_d;
      ful_q <= ful_d;
    end
  end

  assign head_ptr = rd_q;
  assign fill_cnt = cnt_q;

endmodule

// File: rtl/msg_cell_fifo.sv
module msg_cell_fifo
  import msg_cell_pkg::*;
#(
  parameter int N_REQ     = 64,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 64,
  parameter bit FIFO_MODE = 1'b1,
  localparam int ID_W     = $clog2(N_REQ),
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [1:0]        req_view,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_stall,
  output logic [ID_W-1:0]   rsp_stall_id,
  output logic [N_REQ-1:0]  wake_vec
);

  logic [PTR_W-1:0]  head_ptr;
  logic [DATA_W-1:0] head_data;
  logic              st_we;
  logic [PTR_W-1:0]  st_slot;
  logic [DATA_W-1:0] rdata_d;
  logic              stall_d;
  logic              release_d;
  logic [CNT_W-1:0]  fill_cnt;
  logic [N_REQ-1:0]  pend_mask;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              stl_q, stl_d;
  logic [ID_W-1:0]   sid_q, sid_d;

  msg_cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_we),
    .wr_slot   (st_slot),
    .wr_data   (req_wdata),
    .head_slot (head_ptr),
    .head_data (head_data)
  );

  msg_cell_tag #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FIFO_MODE(FIFO_MODE)) i_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (req_valid),
    .acc_view  (view_e'(req_view)),
    .acc_write (req_write),
    .acc_wdata (req_wdata),
    .head_data (head_data),
    .head_ptr  (head_ptr),
    .st_we     (st_we),
    .st_slot   (st_slot),
    .rdata_d   (rdata_d),
    .stall_d   (stall_d),
    .release_d (release_d),
    .fill_cnt  (fill_cnt)
  );

  msg_cell_waitq #(.N_REQ(N_REQ)) i_waitq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_en     (stall_d),
    .rec_id     (req_id),
    .release_en (release_d),
    .pend_mask  (pend_mask),
    .wake_vec   (wake_vec)
  );

  always_comb begin
    vld_d = req_valid;
    dat_d = rdata_d;
    stl_d = stall_d;
    sid_d = stall_d ? req_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      stl_q <= 1'b0;
      sid_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
      stl_q <= stl_d;
      sid_q <= sid_d;
    end
  end

  assign rsp_valid    = vld_q;
  assign rsp_rdata    = dat_q;
  assign rsp_stall    = stl_q;
  assign rsp_stall_id = sid_q;

endmodule

// File: rtl/msg_cell_fifo_chk.sv
module msg_cell_fifo_chk #(
  parameter int N_REQ = 64,
  parameter int DEPTH = 4,
  localparam int ID_W  = $clog2(N_REQ),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ID_W-1:0]  req_id,
  input logic             rsp_valid,
  input logic             rsp_stall,
  input logic [ID_W-1:0]  rsp_stall_id,
  input logic [N_REQ-1:0] wake_vec,
  input logic [N_REQ-1:0] pend_mask,
  input logic [CNT_W-1:0] fill_cnt
);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  p_stall_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (rsp_stall_id == $past(req_id)));

  p_stall_records_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> pend_mask[rsp_stall_id]);

  p_stall_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (wake_vec == '0));

  p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |-> (pend_mask == '0));

  p_wake_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec != '0) |-> ((wake_vec & ~$past(pend_mask)) == '0));

endmodule

bind msg_cell_fifo msg_cell_fifo_chk #(.N_REQ(N_REQ), .DEPTH(DEPTH)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_id       (req_id),
  .rsp_valid    (rsp_valid),
  .rsp_stall    (rsp_stall),
  .rsp_stall_id (rsp_stall_id),
  .wake_vec     (wake_vec),
  .pend_mask    (pend_mask),
  .fill_cnt     (fill_cnt)
);

// File: tb/test_msg_cell_fifo.sv
module test_msg_cell_fifo;

  localparam int NV = 30;

  typedef struct packed {
    logic [1:0]  view;
    logic        wr;
    logic [5:0]  id;
    logic [63:0] wdata;
    logic        stall;
    logic [63:0] rdata;
    logic [63:0] wake;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(logic [1:0] v, logic w, logic [5:0] i, logic [63:0] d,
                              logic s, logic [63:0] r, logic [63:0] k, logic [7:0] q);
    vec_t t;
    t.view = v; t.wr = w; t.id = i; t.wdata = d;
    t.stall = s; t.rdata = r; t.wake = k; t.req = q;
    return t;
  endfunction

  // view codes (R10): 0 raw, 1 tag, 2 waiting, 3 polling
  localparam vec_t VEC [NV] = '{
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20020001, 64'h0,   8'd1),  // 0  R1 reset tag word
    mk(2'd3, 1'b0, 6'd5, 64'h0,     1'b0, 64'h0,        64'h0,   8'd5),  // 1  R5 poll pop empty -> 0
    mk(2'd2, 1'b0, 6'd3, 64'h0,     1'b1, 64'h0,        64'h0,   8'd6),  // 2  R6 wait pop empty stalls
    mk(2'd2, 1'b0, 6'd7, 64'h0,     1'b1, 64'h0,        64'h0,   8'd6),  // 3  R6 second stall
    mk(2'd3, 1'b1, 6'd1, 64'hA1,    1'b0, 64'h0,        64'h88,  8'd8),  // 4  R8 push wakes 3 and 7
    mk(2'd2, 1'b1, 6'd1, 64'hB2,    1'b0, 64'h0,        64'h0,   8'd4),  // 5  R4 wait push not full
    mk(2'd3, 1'b1, 6'd1, 64'hC3,    1'b0, 64'h0,        64'h0,   8'd4),  // 6  R4
    mk(2'd3, 1'b1, 6'd1, 64'hD4,    1'b0, 64'h0,        64'h0,   8'd4),  // 7  R4 reaches depth
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20120002, 64'h0,   8'd4),  // 8  R4 count 4, full
    mk(2'd2, 1'b1, 6'd9, 64'hE5,    1'b1, 64'h0,        64'h0,   8'd7),  // 9  R7 wait push full stalls
    mk(2'd3, 1'b1, 6'd2, 64'hF6,    1'b0, 64'h0,        64'h200, 8'd8),  // 10 R8 poll push full, dropped, wakes 9
    mk(2'd0, 1'b0, 6'd0, 64'h0,     1'b0, 64'hA1,       64'h0,   8'd9),  // 11 R9 raw peek head
    mk(2'd0, 1'b1, 6'd0, 64'h77,    1'b0, 64'h0,        64'h0,   8'd9),  // 12 R9 raw patch newest
    mk(2'd3, 1'b0, 6'd2, 64'h0,     1'b0, 64'hA1,       64'h0,   8'd5),  // 13 R5 pop oldest
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h200E0000, 64'h0,   8'd5),  // 14 R5 full cleared, count 3
    mk(2'd2, 1'b0, 6'd2, 64'h0,     1'b0, 64'hB2,       64'h0,   8'd5),  // 15 R5
    mk(2'd3, 1'b0, 6'd2, 64'h0,     1'b0, 64'hC3,       64'h0,   8'd5),  // 16 R5
    mk(2'd3, 1'b0, 6'd2, 64'h0,     1'b0, 64'h77,       64'h0,   8'd9),  // 17 R9 patched entry popped
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20020001, 64'h0,   8'd5),  // 18 R5 empty again
    mk(2'd3, 1'b1, 6'd1, 64'h11,    1'b0, 64'h0,        64'h0,   8'd4),  // 19 R4 push after wrap
    mk(2'd1, 1'b1, 6'd0, 64'h10002, 1'b0, 64'h0,        64'h0,   8'd3),  // 20 R3 T=1 F=1 E=0
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20070002, 64'h0,   8'd3),  // 21 R3 count kept
    mk(2'd2, 1'b1, 6'd4, 64'h33,    1'b1, 64'h0,        64'h0,   8'd7),  // 22 R7 full flag with room stalls
    mk(2'd1, 1'b1, 6'd0, 64'h1,     1'b0, 64'h0,        64'h0,   8'd3),  // 23 R3 E=1 clears count
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20020001, 64'h0,   8'd3),  // 24 R3
    mk(2'd0, 1'b1, 6'd0, 64'h99,    1'b0, 64'h0,        64'h0,   8'd9),  // 25 R9 raw write on empty dropped
    mk(2'd0, 1'b0, 6'd0, 64'h0,     1'b0, 64'h11,       64'h0,   8'd9),  // 26 R9 stale head intact
    mk(2'd3, 1'b1, 6'd6, 64'h22,    1'b0, 64'h0,        64'h10,  8'd8),  // 27 R8 push wakes 4
    mk(2'd3, 1'b0, 6'd6, 64'h0,     1'b0, 64'h22,       64'h0,   8'd5),  // 28 R5
    mk(2'd1, 1'b0, 6'd0, 64'h0,     1'b0, 64'h20020001, 64'h0,   8'd5)   // 29 R5
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_id;
  logic [1:0]  req_view;
  logic        req_write;
  logic [63:0] req_wdata;
  logic        rsp_valid,   rsp_stall;
  logic [63:0] rsp_rdata,   wake_vec;
  logic [5:0]  rsp_stall_id;
  logic        s_valid,     s_stall;
  logic [63:0] s_rdata,     s_wake;
  logic [5:0]  s_stall_id;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  msg_cell_fifo i_msg_cell_fifo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_view(req_view), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .rsp_stall_id(rsp_stall_id), .wake_vec(wake_vec)
  );

  msg_cell_fifo #(.FIFO_MODE(1'b0)) i_msg_cell_fifo_plain (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_view(req_view), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(s_valid), .rsp_rdata(s_rdata), .rsp_stall(s_stall),
    .rsp_stall_id(s_stall_id), .wake_vec(s_wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input logic w, input logic [5:0] i, input logic [63:0] d);
    req_valid = 1'b1; req_view = v; req_write = w; req_id = i; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    req_valid = 1'b0; req_id = '0; req_view = '0; req_write = 1'b0; req_wdata = '0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 / R2: quiet outputs after reset
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    chk("R1 wake_vec after reset", wake_vec, 64'h0);
    chk("R1 rsp_stall after reset", 64'(rsp_stall), 64'h0);

    for (int n = 0; n < NV; n++) begin
      drive(VEC[n].view, VEC[n].wr, VEC[n].id, VEC[n].wdata);
      chk($sformatf("R2 vec%0d rsp_valid (R%0d)", n, VEC[n].req), 64'(rsp_valid), 64'h1);
      chk($sformatf("vec%0d rdata R%0d", n, VEC[n].req), rsp_rdata, VEC[n].rdata);
      chk($sformatf("vec%0d stall R%0d", n, VEC[n].req), 64'(rsp_stall), 64'(VEC[n].stall));
      if (VEC[n].stall) begin
        chk($sformatf("vec%0d stall id R%0d", n, VEC[n].req), 64'(rsp_stall_id), 64'(VEC[n].id));
      end
      chk($sformatf("vec%0d wake R%0d", n, VEC[n].req), wake_vec, VEC[n].wake);
    end

    // R2: idle cycle gives no response, wake pulse gone
    @(negedge clk);
    chk("R2 no response when idle", 64'(rsp_valid), 64'h0);
    chk("R8 wake lasts one cycle", wake_vec, 64'h0);

    // R1: reset empties pending set
    drive(2'd2, 1'b0, 6'd11, 64'h0);
    chk("R6 stall before reset", 64'(rsp_stall), 64'h1);
    do_reset();
    drive(2'd3, 1'b1, 6'd0, 64'h5);
    chk("R1 no wake after reset", wake_vec, 64'h0);

    // R11: non-queue cell
    do_reset();
    drive(2'd1, 1'b0, 6'd0, 64'h0);
    chk("R11 plain tag word at reset", s_rdata, 64'h0);
    drive(2'd1, 1'b1, 6'd0, 64'h1);
    drive(2'd3, 1'b1, 6'd2, 64'h55);
    chk("R11 plain push no wake", s_wake, 64'h0);
    drive(2'd2, 1'b0, 6'd3, 64'h0);
    chk("R11 plain pop returns 0", s_rdata, 64'h0);
    chk("R11 plain pop no stall", 64'(s_stall), 64'h0);
    drive(2'd1, 1'b0, 6'd0, 64'h0);
    chk("R11 plain push left flags", s_rdata, 64'h1);
    drive(2'd0, 1'b0, 6'd0, 64'h0);
    chk("R11 plain nothing stored", s_rdata, 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule